// File: doc/BRIEF.md
# Quadrature Decoder with Position Capture

This block is the front end for one incremental encoder axis. It brings the raw A, B, active-low index and active-low home lines into the clock domain and filters out short glitches. It then decodes the filtered A/B pair into single up or down steps, which drive a 32-bit signed actual-position counter.

The block can also latch the running position into a capture register. The trigger is either an index event or a falling edge on the home line, picked by a select input. After a capture, the capture-valid flag stays set and the interrupt request pulses once. Further triggers are dropped until the host reads the captured value and pulses the acknowledge input.

Top module: `quad_capture`

## Requirements
- R1: With {A,B} stepping through 00, 10, 11, 01 and back to 00 (A leading B), each accepted state change adds one to `position`.
- R2: Stepping the same sequence in the opposite order subtracts one per accepted state change.
- R3: A new level on any input is accepted only after it has been sampled unchanged on 5 consecutive clocks. A level held for 4 clocks and then withdrawn leaves `position` unchanged.
- R4: An accepted A/B change in which both A and B flip together (a phase jump of two) leaves `position` unchanged and raises `step_err` for exactly one clock.
- R5: After a synchronous reset, `position` and `cap_value` are 0, and `cap_valid`, `irq` and `step_err` are low.
- R6: With `cap_sel`=0, an index event is the first clock on which the filtered index, A and B are all low together. It loads `cap_value` with the position that includes the step that completed the event.
- R7: With `cap_sel`=1, a high-to-low change of the filtered home line loads `cap_value` with the current position, whatever the A and B levels are.
- R8: `cap_valid` sets on a capture and stays set until `cap_ack` is sampled high. While it is set, `cap_value` holds and new triggers are ignored.
- R9: `irq` is high for exactly one clock for each capture taken.
- R10: No capture occurs in any of these cases: the index and home lines are held high; the index is low while A or B is high; or the trigger comes from the source that `cap_sel` does not select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_a | input | 1 | Raw encoder channel A |
| enc_b | input | 1 | Raw encoder channel B |
| index_n | input | 1 | Raw encoder index, active low |
| home_n | input | 1 | Raw home switch, active low |
| cap_sel | input | 1 | Capture source: 0 index, 1 home |
| cap_ack | input | 1 | Host has read the captured value; clears `cap_valid` |
| position | output | 32 | Signed actual position |
| cap_value | output | 32 | Signed captured position |
| cap_valid | output | 1 | Capture register holds an unread value |
| irq | output | 1 | One-clock interrupt request on each capture |
| step_err | output | 1 | One-clock pulse on an illegal double transition |

## Verification
The embedded assertions check four rules on every clock:
- the filter output only changes after a full run of equal samples;
- `position` moves by at most one per clock and never moves on a `step_err` clock;
- an unacknowledged capture holds its value and flag;
- every `irq` pulse coincides with a fresh capture.

Other behaviour can only be shown by the bench's scenarios:
- the direction of counting;
- the exact glitch width that is rejected;
- which position value an index or home event latches;
- that an unselected or gated-off trigger never captures.

The bench shows these by sweeping long forward, reverse and mixed step sequences against an arithmetic position model.

// File: rtl/qc_pkg.sv
// Shared definitions for the quadrature capture block.
// Assumes {A,B} phase order 00,10,11,01 is forward motion.
package qc_pkg;
    parameter int POS_W = 32;

    typedef enum logic [0:0] {
        SRC_INDEX = 1'b0,
        SRC_HOME  = 1'b1
    } cap_src_e;

    // Map an {A,B} level pair to its position in the forward cycle.
    function automatic logic [1:0] phase_of(input logic [1:0] ab);
        case (ab)
            2'b00:   phase_of = 2'd0;
            2'b10:   phase_of = 2'd1;
            2'b11:   phase_of = 2'd2;
            default: phase_of = 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/qc_filter.sv
// Synchronizer plus run-length glitch filter for a W-bit input group.
// A new value passes only after LEN equal consecutive samples. The bits of
// the group are judged together, so a simultaneous change stays visible.
// Assumes SYNC >= 1. vld rises on the first accepted value after reset.
module qc_filter #(
    parameter int           W       = 1,
    parameter int           LEN     = 5,
    parameter int           SYNC    = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] filt,
    output logic         vld
);
    localparam int             CW   = $clog2(LEN + 1);
    localparam logic [CW-1:0]  LAST = CW'(LEN - 1);
    localparam logic [CW-1:0]  FULL = CW'(LEN);

    logic [SYNC-1:0][W-1:0] sync_q;
    logic [W-1:0]           samp;
    logic [W-1:0]           cand;
    logic [CW-1:0]          cnt;

    assign samp = sync_q[SYNC-1];

    // Purpose: move the raw input through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {SYNC{RST_VAL}};
        end else begin
            for (int i = SYNC - 1; i > 0; i--) sync_q[i] <= sync_q[i-1];
            sync_q[0] <= raw;
        end
    end

    // Purpose: count equal samples and release a value after LEN of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand <= RST_VAL;
            cnt  <= '0;
            filt <= RST_VAL;
            vld  <= 1'b0;
        end else begin
            if (samp != cand) begin
                cand <= samp;
                cnt  <= CW'(1);
            end else if (cnt != FULL) begin
                cnt <= cnt + 1'b1;
            end
            if (samp == cand && cnt == LAST) begin
                filt <= cand;
                vld  <= 1'b1;
            end
        end
    end

    // R3: the output moves only at the end of a full run of equal samples
    p_run_before_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt) |-> ($past(cnt) == LAST && $past(samp) == filt));
endmodule

// File: rtl/qc_counter.sv
// Quadrature step decoder and signed position counter.
// Compares the filtered {A,B} with the previous filtered value. It makes a
// step of +1 or -1, or flags a jump of two phases as an error.
// pos_next exposes the value being loaded this clock.
module qc_counter
    import qc_pkg::*;
#(
    parameter int POS_W_P = POS_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               ab,
    input  logic                     ab_vld,
    output logic signed [POS_W_P-1:0] position,
    output logic signed [POS_W_P-1:0] pos_next,
    output logic                     step_err
);
    localparam logic signed [POS_W_P-1:0] ONE = POS_W_P'(1);

    logic [1:0] ab_q;
    logic       vld_q;
    logic [1:0] diff;
    logic       moved;

    // Purpose: decode the phase difference into the next position value.
    always_comb begin
        diff     = phase_of(ab) - phase_of(ab_q);
        moved    = ab_vld && vld_q && (ab != ab_q);
        pos_next = position;
        if (moved && diff == 2'd1)      pos_next = position + ONE;
        else if (moved && diff == 2'd3) pos_next = position - ONE;
    end

    // Purpose: hold the previous phase, the position and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ab_q     <= 2'b00;
            vld_q    <= 1'b0;
            position <= '0;
            step_err <= 1'b0;
        end else begin
            ab_q     <= ab;
            vld_q    <= ab_vld;
            position <= pos_next;
            step_err <= moved && (diff == 2'd2);
        end
    end

    // R1/R2: the counter never moves by more than one per clock
    p_unit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (position == $past(position)) || (position == $past(position) + ONE) ||
        (position == $past(position) - ONE));

    // R4: an illegal transition never changes the count
    p_err_holds_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step_err |-> (position == $past(position)));
endmodule

// File: rtl/qc_capture.sv
// Capture trigger detection and the capture register.
// Index event: first clock on which filtered index, A and B are all low.
// Home event: falling edge of the filtered home line.
// A trigger is taken only while no unread capture is pending.
module qc_capture
    import qc_pkg::*;
#(
    parameter int POS_W_P = POS_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                ab,
    input  logic                      ab_vld,
    input  logic                      idx_n,
    input  logic                      idx_vld,
    input  logic                      home_n,
    input  logic                      home_vld,
    input  logic                      cap_sel,
    input  logic                      cap_ack,
    input  logic signed [POS_W_P-1:0] pos_next,
    output logic signed [POS_W_P-1:0] cap_value,
    output logic                      cap_valid,
    output logic                      irq
);
    logic all_low, all_low_q, home_q;
    logic idx_evt, home_evt, trig, take;

    // Purpose: form the trigger of the selected source and the capture enable.
    always_comb begin
        all_low  = ab_vld && idx_vld && (ab == 2'b00) && !idx_n;
        idx_evt  = all_low && !all_low_q;
        home_evt = home_vld && home_q && !home_n;
        trig     = (cap_src_e'(cap_sel) == SRC_HOME) ? home_evt : idx_evt;
        take     = trig && !cap_valid;
    end

    // Purpose: keep edge history, load the capture, manage the flag and request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            all_low_q <= 1'b0;
            home_q    <= 1'b1;
            cap_value <= '0;
            cap_valid <= 1'b0;
            irq       <= 1'b0;
        end else begin
            all_low_q <= all_low;
            home_q    <= home_n;
            irq       <= take;
            if (take) begin
                cap_value <= pos_next;
                cap_valid <= 1'b1;
            end else if (cap_ack) begin
                cap_valid <= 1'b0;
            end
        end
    end

    // R8: a pending capture is kept intact until acknowledged
    p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !cap_ack) |=> (cap_valid && $stable(cap_value)));

    // R9: each request marks a capture that was not pending before
    p_irq_fresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cap_valid && !$past(cap_valid)));
endmodule

// File: rtl/quad_capture.sv
// Top of the single-axis encoder front end.
// It filters the A/B pair as one group so a double flip stays detectable,
// and filters index and home separately. It decodes steps into the position
// counter and captures position on the selected trigger.
module quad_capture
    import qc_pkg::*;
#(
    parameter int FILT_LEN = 5,
    parameter int SYNC_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             index_n,
    input  logic             home_n,
    input  logic             cap_sel,
    input  logic             cap_ack,
    output logic [POS_W-1:0] position,
    output logic [POS_W-1:0] cap_value,
    output logic             cap_valid,
    output logic             irq,
    output logic             step_err
);
    localparam int AB_W = 2;

    logic [AB_W-1:0]          ab_f;
    logic                     ab_vld, idx_f, idx_vld, home_f, home_vld;
    logic signed [POS_W-1:0]  pos_s, pos_nx, cap_s;

    qc_filter #(.W(AB_W), .LEN(FILT_LEN), .SYNC(SYNC_LEN), .RST_VAL(2'b00)) u_ab (
        .clk(clk), .rst_n(rst_n), .raw({enc_a, enc_b}), .filt(ab_f), .vld(ab_vld));

    qc_filter #(.W(1), .LEN(FILT_LEN), .SYNC(SYNC_LEN), .RST_VAL(1'b1)) u_idx (
        .clk(clk), .rst_n(rst_n), .raw(index_n), .filt(idx_f), .vld(idx_vld));

    qc_filter #(.W(1), .LEN(FILT_LEN), .SYNC(SYNC_LEN), .RST_VAL(1'b1)) u_home (
        .clk(clk), .rst_n(rst_n), .raw(home_n), .filt(home_f), .vld(home_vld));

    qc_counter #(.POS_W_P(POS_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ab(ab_f), .ab_vld(ab_vld),
        .position(pos_s), .pos_next(pos_nx), .step_err(step_err));

    qc_capture #(.POS_W_P(POS_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .ab(ab_f), .ab_vld(ab_vld),
        .idx_n(idx_f), .idx_vld(idx_vld), .home_n(home_f), .home_vld(home_vld),
        .cap_sel(cap_sel), .cap_ack(cap_ack), .pos_next(pos_nx),
        .cap_value(cap_s), .cap_valid(cap_valid), .irq(irq));

    assign position  = pos_s;
    assign cap_value = cap_s;
endmodule

// File: tb/sim_quad_capture.sv
// Self-checking bench for quad_capture: step sweeps against an arithmetic model.
module sim_quad_capture;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, enc_a, enc_b, index_n, home_n, cap_sel, cap_ack;
    logic [31:0] position, cap_value;
    logic        cap_valid, irq, step_err;

    quad_capture u0 (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .index_n(index_n),
        .home_n(home_n), .cap_sel(cap_sel), .cap_ack(cap_ack), .position(position),
        .cap_value(cap_value), .cap_valid(cap_valid), .irq(irq), .step_err(step_err));

    int     n_cmp = 0, n_bad = 0, irq_seen = 0, err_seen = 0;
    int     ph = 0;
    longint expp = 0;

    // Count request and error pulses, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && irq)      irq_seen++;
        if (rst_n && step_err) err_seen++;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [1:0] ab_of(input int p);
        case (p)
            0:       ab_of = 2'b00;
            1:       ab_of = 2'b10;
            2:       ab_of = 2'b11;
            default: ab_of = 2'b01;
        endcase
    endfunction

    function automatic longint pos_now();
        pos_now = longint'($signed(position));
    endfunction

    // One encoder step in direction dir (+1 forward), then let it settle.
    task automatic step(input int dir);
        ph = (ph + dir + 4) % 4;
        {enc_a, enc_b} = ab_of(ph);
        expp += dir;
        wait_cyc(12);
    endtask

    task automatic ack_pulse();
        cap_ack = 1'b1;
        wait_cyc(1);
        cap_ack = 1'b0;
        wait_cyc(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        longint base, hi, cap_old;
        int     irq0, err0;
        bit     moved;
        rst_n = 1'b0; enc_a = 1'b0; enc_b = 1'b0; index_n = 1'b1; home_n = 1'b1;
        cap_sel = 1'b0; cap_ack = 1'b0;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        // R5: reset state
        chk("R5 position", pos_now(), 0);
        chk("R5 cap_value", cap_value, 0);
        chk("R5 cap_valid", cap_valid, 0);
        chk("R5 irq", irq, 0);
        chk("R5 step_err", step_err, 0);
        wait_cyc(10);

        // R1: forward sweep
        for (int i = 0; i < 24; i++) begin
            step(1);
            chk("R1 forward", pos_now(), expp);
        end
        // R2: reverse sweep through zero into negative counts
        for (int i = 0; i < 40; i++) begin
            step(-1);
            chk("R2 reverse", pos_now(), expp);
        end
        // R1/R2: mixed direction pattern
        for (int i = 0; i < 18; i++) begin
            step((i % 3 == 0) ? -1 : 1);
            chk("R1 R2 mixed", pos_now(), expp);
        end

        // R3: a 4-clock glitch is rejected
        base  = expp;
        moved = 1'b0;
        {enc_a, enc_b} = ab_of((ph + 1) % 4);
        wait_cyc(4);
        {enc_a, enc_b} = ab_of(ph);
        for (int i = 0; i < 20; i++) begin
            wait_cyc(1);
            if (pos_now() != base) moved = 1'b1;
        end
        chk("R3 short glitch ignored", moved, 0);
        // R3: a 5-clock level is accepted, then its withdrawal too
        hi = base;
        {enc_a, enc_b} = ab_of((ph + 1) % 4);
        wait_cyc(5);
        {enc_a, enc_b} = ab_of(ph);
        for (int i = 0; i < 20; i++) begin
            wait_cyc(1);
            if (pos_now() > hi) hi = pos_now();
        end
        chk("R3 five samples accepted", hi, base + 1);
        chk("R3 returns", pos_now(), base);

        // R4: both channels flip together
        err0 = err_seen;
        ph = (ph + 2) % 4;
        {enc_a, enc_b} = ab_of(ph);
        wait_cyc(12);
        chk("R4 count held", pos_now(), expp);
        chk("R4 one error pulse", err_seen - err0, 1);
        step(1);
        chk("R4 recovers", pos_now(), expp);

        // R10: index low while A/B not both low does not capture
        while (ph != 1) step(1);
        index_n = 1'b0;
        wait_cyc(12);
        chk("R10 gated index", cap_valid, 0);
        // R6: final step into 00 completes the index event
        irq0 = irq_seen;
        step(-1);
        chk("R6 index valid", cap_valid, 1);
        chk("R6 index value", longint'($signed(cap_value)), expp);
        chk("R9 one irq", irq_seen - irq0, 1);
        // R8: a further event while pending is ignored
        cap_old = expp;
        for (int i = 0; i < 4; i++) step(1);
        chk("R8 value kept", longint'($signed(cap_value)), cap_old);
        chk("R8 no new irq", irq_seen - irq0, 1);
        ack_pulse();
        chk("R8 ack clears", cap_valid, 0);
        for (int i = 0; i < 4; i++) step(1);
        chk("R6 recapture", longint'($signed(cap_value)), expp);
        chk("R9 second irq", irq_seen - irq0, 2);
        ack_pulse();

        // R10: index events ignored while home is selected
        cap_sel = 1'b1;
        for (int i = 0; i < 8; i++) step(-1);
        chk("R10 unselected index", cap_valid, 0);
        index_n = 1'b1;
        wait_cyc(12);

        // R7: home falling edge captures at any A/B level
        step(1);
        irq0 = irq_seen;
        home_n = 1'b0;
        wait_cyc(12);
        chk("R7 home valid", cap_valid, 1);
        chk("R7 home value", longint'($signed(cap_value)), expp);
        chk("R9 home irq", irq_seen - irq0, 1);
        ack_pulse();
        for (int i = 0; i < 5; i++) step(1);
        chk("R7 level is not an edge", cap_valid, 0);
        home_n = 1'b1;
        wait_cyc(12);

        // R10: idle-high index and home never capture, either selection
        for (int i = 0; i < 8; i++) begin
            cap_sel = i[0];
            step(1);
        end
        chk("R10 idle inputs", cap_valid, 0);
        chk("R10 idle irq", irq_seen - irq0, 1);
        chk("R1 final position", pos_now(), expp);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule